// File: doc/BRIEF.md
# SPI Character Engine

This block moves 8-bit characters over a four-wire synchronous serial link. It can be the clock-owning side (master) or the clock-following side (slave). A 3-bit register port gives software a configuration register, a transmit holding register, a receive holding register, a status word and a write-lock register. A character written to the transmit holding register is shifted out most significant bit first. At the same time a character is shifted in. When the eighth bit arrives, that byte is placed in the receive holding register.

Register offsets on `reg_addr`:

| Offset | Register | Access |
|---|---|---|
| 0 | configuration | read/write |
| 1 | transmit holding | write-only, reads back 0 |
| 2 | receive holding | reading it clears RXRDY |
| 3 | status | bit 0 TXRDY, bit 1 RXRDY, bit 2 overrun. Writing a 1 to bit 2 clears overrun |
| 4 | write-lock | bit 0 |

Configuration fields:

| Bits | Field | Meaning |
|---|---|---|
| 3:0 | role | 0xE master, 0xF slave, any other value turns the serial side off |
| 5:4 | clock source | 0 internal clock, 1 internal clock divided by 8, 3 external SCK |
| 7:6 | character length | stored and read back, 3 means 8 bits |
| 8 | phase | |
| 16 | polarity | |
| 18 | clock-out enable | |
| 20 | wait-for-read | |

In master mode, each SCK half-period lasts `HALF_TICKS` pulses of the selected clock source. In slave mode, the engine follows a synchronized copy of the external SCK, and it does so only while its select input is low.

Top module: `spi_char_engine`

## Requirements
- R1: After reset the configuration register reads 0, status reads 1 (TXRDY set, RXRDY and overrun clear), `sel_n_o` is high and `sck_oe` is low.
- R2: While configuration bits 3:0 are neither 0xE nor 0xF, no transfer starts: `sel_n_o` stays high and a written character stays pending (TXRDY 0).
- R3: In master mode, a written character is sent MSB first on `mosi_o`, and the byte received on `miso_i` is placed in the receive holding register with RXRDY set. Reading offset 2 returns that byte and clears RXRDY.
- R4: In master mode, SCK rests at the level of bit 16 when idle and makes 16 edges per character. With bit 8 at 0, data is sampled on the leading edges (1st, 3rd and so on) and changes on the trailing ones. With bit 8 at 1, the two roles are swapped.
- R5: Clock source 1 makes each master character at least 7 times longer than clock source 0. With source 0 a character lasts at least 16·`HALF_TICKS` cycles.
- R6: `sck_oe` is high only in master mode with bit 18 set and a clock source other than 3.
- R7: With bit 20 set, a pending character does not start while RXRDY is set. It starts once offset 2 has been read.
- R8: While write-lock bit 0 is 1, writes to the configuration register are ignored. With the bit at 0, writes take effect.
- R9: Writing offset 1 clears TXRDY on the next cycle. TXRDY sets again when the character moves into the shift register.
- R10: If a character completes while RXRDY is still set, status bit 2 sets and the held byte is kept. Writing 1 to status bit 2 clears it.
- R11: In slave mode with `sel_n_i` low, the engine receives a byte on `mosi_i` and sends the pending character on `miso_o`, using the same polarity and phase rules. With `sel_n_i` high, SCK activity is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | internal clock |
| rst | input | 1 | synchronous reset, active high |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe (side effects only) |
| reg_addr | input | 3 | register offset |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data for `reg_addr` |
| sck_i | input | 1 | external serial clock |
| sck_o | output | 1 | serial clock driven in master mode |
| sck_oe | output | 1 | enable for `sck_o` |
| mosi_o | output | 1 | master data out |
| mosi_i | input | 1 | slave data in |
| miso_o | output | 1 | slave data out |
| miso_i | input | 1 | master data in |
| sel_n_o | output | 1 | master select, low during a character |
| sel_n_i | input | 1 | slave select, active low |

## Verification
The master path is exercised in loopback with the bytes A5, 3C, 81 and 6E, one for each polarity/phase pair. These patterns show a bit-order reversal, a wrong sampling edge and a missing first-edge hold: each of those faults would corrupt at least one of the four bytes. The bench counts SCK edges and records `mosi_o` on the sampling edges, which separates correct shifting from a loopback that only happens to match. The slave path is driven by a bench master, once with slow edges per phase and once while deselected, which tells a proper select qualification apart from blind edge counting. Back-to-back characters, sent with and without the wait-for-read gate, separate the overrun behaviour from the hold-back behaviour.

// File: rtl/spi_eng_pkg.sv
`timescale 1ns/1ps
package spi_eng_pkg;

    localparam logic [3:0]  ROLE_MASTER = 4'hE;
    localparam logic [3:0]  ROLE_SLAVE  = 4'hF;
    localparam logic [1:0]  SRC_PCLK    = 2'd0;
    localparam logic [1:0]  SRC_DIV     = 2'd1;
    localparam logic [1:0]  SRC_EXT     = 2'd3;
    localparam int          DIV_RATIO   = 8;
    // implemented configuration bits: role, source, length, phase, polarity, clock-out, wait
    localparam logic [31:0] MODE_KEEP   = 32'h0015_01FF;

    typedef enum logic [2:0] {
        ADR_MODE  = 3'd0,
        ADR_TXH   = 3'd1,
        ADR_RXH   = 3'd2,
        ADR_STAT  = 3'd3,
        ADR_WPROT = 3'd4
    } adr_e;

    typedef struct packed {
        logic       master;
        logic       slave;
        logic [1:0] src;
        logic       cpha;
        logic       cpol;
        logic       clko;
        logic       wrgate;
    } cfg_t;

    // leading edges are the even-numbered ones; phase 1 moves sampling to the trailing ones
    function automatic logic is_sample_edge(input logic lead, input logic cpha);
        return lead ^ cpha;
    endfunction

endpackage

// File: rtl/spi_eng_regs.sv
`timescale 1ns/1ps
module spi_eng_regs
    import spi_eng_pkg::*;
#(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          load_tx,
    input  logic          char_done,
    input  logic [W-1:0]  rx_byte,
    output cfg_t          cfg,
    output logic [31:0]   mode_q,
    output logic [W-1:0]  thr_q,
    output logic [W-1:0]  rhr_q,
    output logic          txrdy,
    output logic          rxrdy,
    output logic          ovr,
    output logic          wp_en
);

    logic wr_mode, wr_tx, wr_stat, wr_wp, rd_rx;

    assign wr_mode = reg_wr && (reg_addr == ADR_MODE) && !wp_en;
    assign wr_tx   = reg_wr && (reg_addr == ADR_TXH);
    assign wr_stat = reg_wr && (reg_addr == ADR_STAT);
    assign wr_wp   = reg_wr && (reg_addr == ADR_WPROT);
    assign rd_rx   = reg_rd && (reg_addr == ADR_RXH);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            wp_en  <= 1'b0;
            thr_q  <= '0;
            rhr_q  <= '0;
            txrdy  <= 1'b1;
            rxrdy  <= 1'b0;
            ovr    <= 1'b0;
        end else begin
            if (wr_mode) mode_q <= reg_wdata & MODE_KEEP;
            if (wr_wp)   wp_en  <= reg_wdata[0];

            if (wr_tx) begin
                thr_q <= reg_wdata[W-1:0];
                txrdy <= 1'b0;
            end else if (load_tx) begin
                txrdy <= 1'b1;
            end

            if (char_done) begin
                if (rxrdy && !rd_rx) begin
                    ovr <= 1'b1;
                end else begin
                    rhr_q <= rx_byte;
                    rxrdy <= 1'b1;
                end
            end else if (rd_rx) begin
                rxrdy <= 1'b0;
            end

            if (wr_stat && reg_wdata[2] && !(char_done && rxrdy && !rd_rx)) ovr <= 1'b0;
        end
    end

    always_comb begin
        cfg.master = (mode_q[3:0] == ROLE_MASTER);
        cfg.slave  = (mode_q[3:0] == ROLE_SLAVE);
        cfg.src    = mode_q[5:4];
        cfg.cpha   = mode_q[8];
        cfg.cpol   = mode_q[16];
        cfg.clko   = mode_q[18];
        cfg.wrgate = mode_q[20];
    end

    always_comb begin
        case (adr_e'(reg_addr))
            ADR_MODE:  reg_rdata = mode_q;
            ADR_RXH:   reg_rdata = 32'(rhr_q);
            ADR_STAT:  reg_rdata = {29'd0, ovr, rxrdy, txrdy};
            ADR_WPROT: reg_rdata = {31'd0, wp_en};
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_eng_pace.sv
`timescale 1ns/1ps
module spi_eng_pace
    import spi_eng_pkg::*;
#(
    parameter int HALF = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] src,
    input  logic       run,
    input  logic       sck_i,
    input  logic       sel_n_i,
    input  logic       mosi_i,
    output logic       m_edge,
    output logic       s_edge,
    output logic       sel_act,
    output logic       mosi_s
);

    localparam int DVW = $clog2(DIV_RATIO);
    localparam int HW  = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [DVW-1:0] DV_LAST = DVW'(DIV_RATIO - 1);
    localparam logic [HW-1:0]  H_LAST  = HW'(HALF - 1);

    logic [2:0]     sk;
    logic [1:0]     sl;
    logic [1:0]     mo;
    logic [DVW-1:0] dv;
    logic [HW-1:0]  hc;
    logic           tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            sk <= '0;
            sl <= 2'b11;
            mo <= '0;
            dv <= '0;
        end else begin
            sk <= {sk[1:0], sck_i};
            sl <= {sl[0], sel_n_i};
            mo <= {mo[0], mosi_i};
            dv <= dv + 1'b1;
        end
    end

    always_comb begin
        case (src)
            SRC_DIV: tick = (dv == DV_LAST);
            SRC_EXT: tick = sk[1] & ~sk[2];
            default: tick = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !run)        hc <= '0;
        else if (tick)          hc <= (hc == H_LAST) ? '0 : hc + 1'b1;
    end

    assign m_edge  = run && tick && (hc == H_LAST);
    assign s_edge  = sk[2] ^ sk[1];
    assign sel_act = ~sl[1];
    assign mosi_s  = mo[1];

endmodule

// File: rtl/spi_eng_shift.sv
`timescale 1ns/1ps
module spi_eng_shift
    import spi_eng_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         is_master,
    input  logic         is_slave,
    input  logic         cpha,
    input  logic         tx_avail,
    input  logic         m_edge,
    input  logic         s_edge,
    input  logic         sel_act,
    input  logic         miso_i,
    input  logic         mosi_s,
    input  logic [W-1:0] thr_q,
    output logic         busy,
    output logic         phase,
    output logic         load_tx,
    output logic         char_done,
    output logic [W-1:0] rx_byte,
    output logic         tx_bit
);

    localparam int EDGES = 2 * W;
    localparam int EW    = $clog2(EDGES);
    localparam logic [EW-1:0] E_LAST = EW'(EDGES - 1);

    logic [EW-1:0] ecnt;
    logic [W-1:0]  tx_sh, rx_sh, rx_nx;
    logic          m_start, s_start, ev, smp, din, abort;

    assign m_start   = is_master && !busy && tx_avail;
    assign s_start   = is_slave && !busy && sel_act;
    assign load_tx   = m_start || (s_start && tx_avail);
    assign ev        = busy && (is_master ? m_edge : (s_edge && sel_act));
    assign smp       = is_sample_edge(~ecnt[0], cpha);
    assign din       = is_master ? miso_i : mosi_s;
    assign rx_nx     = {rx_sh[W-2:0], din};
    assign char_done = ev && (ecnt == E_LAST);
    assign rx_byte   = smp ? rx_nx : rx_sh;
    assign abort     = busy && (!(is_master || is_slave) || (is_slave && !sel_act));
    assign tx_bit    = tx_sh[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            ecnt  <= '0;
            phase <= 1'b0;
            tx_sh <= '0;
            rx_sh <= '0;
        end else if (abort || char_done) begin
            busy  <= 1'b0;
            ecnt  <= '0;
            phase <= 1'b0;
        end else if (m_start || s_start) begin
            busy  <= 1'b1;
            ecnt  <= '0;
            phase <= 1'b0;
            if (load_tx) tx_sh <= thr_q;
        end else if (ev) begin
            ecnt  <= ecnt + 1'b1;
            phase <= ~phase;
            if (smp)
                rx_sh <= rx_nx;
            else if (!(cpha && ecnt == '0))
                tx_sh <= {tx_sh[W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/spi_char_engine.sv
`timescale 1ns/1ps
module spi_char_engine
    import spi_eng_pkg::*;
#(
    parameter int CHAR_W     = 8,
    parameter int HALF_TICKS = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        sck_i,
    output logic        sck_o,
    output logic        sck_oe,
    output logic        mosi_o,
    input  logic        mosi_i,
    output logic        miso_o,
    input  logic        miso_i,
    output logic        sel_n_o,
    input  logic        sel_n_i
);

    cfg_t              cfg;
    logic [31:0]       mode_q;
    logic [CHAR_W-1:0] thr_q, rhr_q, rx_byte;
    logic              txrdy, rxrdy, ovr, wp_en;
    logic              busy, phase, load_tx, char_done, tx_bit, tx_avail;
    logic              m_edge, s_edge, sel_act, mosi_s;

    assign tx_avail = !txrdy && (!cfg.wrgate || !rxrdy);

    spi_eng_regs #(.W(CHAR_W)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .load_tx(load_tx),
        .char_done(char_done), .rx_byte(rx_byte), .cfg(cfg), .mode_q(mode_q),
        .thr_q(thr_q), .rhr_q(rhr_q), .txrdy(txrdy), .rxrdy(rxrdy), .ovr(ovr), .wp_en(wp_en)
    );

    spi_eng_pace #(.HALF(HALF_TICKS)) u_pace (
        .clk(clk), .rst(rst), .src(cfg.src), .run(busy && cfg.master), .sck_i(sck_i),
        .sel_n_i(sel_n_i), .mosi_i(mosi_i), .m_edge(m_edge), .s_edge(s_edge),
        .sel_act(sel_act), .mosi_s(mosi_s)
    );

    spi_eng_shift #(.W(CHAR_W)) u_shift (
        .clk(clk), .rst(rst), .is_master(cfg.master), .is_slave(cfg.slave), .cpha(cfg.cpha),
        .tx_avail(tx_avail), .m_edge(m_edge), .s_edge(s_edge), .sel_act(sel_act),
        .miso_i(miso_i), .mosi_s(mosi_s), .thr_q(thr_q), .busy(busy), .phase(phase),
        .load_tx(load_tx), .char_done(char_done), .rx_byte(rx_byte), .tx_bit(tx_bit)
    );

    assign mosi_o  = tx_bit;
    assign miso_o  = tx_bit;
    assign sel_n_o = !(busy && cfg.master);
    assign sck_o   = cfg.cpol ^ phase;
    assign sck_oe  = cfg.master && cfg.clko && (cfg.src != SRC_EXT);

endmodule

// File: rtl/spi_eng_chk.sv
`timescale 1ns/1ps
module spi_eng_chk
    import spi_eng_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         reg_wr,
    input logic         reg_rd,
    input logic [2:0]   reg_addr,
    input logic [31:0]  mode_q,
    input logic         sel_n_o,
    input logic         sck_o,
    input logic         txrdy,
    input logic         rxrdy,
    input logic         ovr,
    input logic         wp_en,
    input logic         char_done,
    input logic [W-1:0] rhr_q
);

    logic rd_rx, is_m, off;
    assign rd_rx = reg_rd && (reg_addr == ADR_RXH);
    assign is_m  = (mode_q[3:0] == ROLE_MASTER);
    assign off   = (mode_q[3:0] != ROLE_MASTER) && (mode_q[3:0] != ROLE_SLAVE);

    a_r2_idle_when_off: assert property (@(posedge clk) disable iff (rst)
        off |=> sel_n_o);

    a_r3_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_rx && !char_done) |=> !rxrdy);

    a_r4_idle_level: assert property (@(posedge clk) disable iff (rst)
        (is_m && sel_n_o) |-> (sck_o == mode_q[16]));

    a_r7_wait_read: assert property (@(posedge clk) disable iff (rst)
        (is_m && mode_q[20] && rxrdy && !rd_rx && sel_n_o) |=> sel_n_o);

    a_r8_locked: assert property (@(posedge clk) disable iff (rst)
        (wp_en && reg_wr && reg_addr == ADR_MODE) |=> $stable(mode_q));

    a_r9_tx_write: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADR_TXH) |=> !txrdy);

    a_r10_keep_old: assert property (@(posedge clk) disable iff (rst)
        (char_done && rxrdy && !rd_rx) |=> (ovr && $stable(rhr_q)));

endmodule

bind spi_char_engine spi_eng_chk #(.W(CHAR_W)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .mode_q(mode_q), .sel_n_o(sel_n_o), .sck_o(sck_o), .txrdy(txrdy), .rxrdy(rxrdy),
    .ovr(ovr), .wp_en(wp_en), .char_done(char_done), .rhr_q(rhr_q)
);

// File: tb/tb_spi_char_engine.sv
`timescale 1ns/1ps
module tb_spi_char_engine;
    import spi_eng_pkg::*;

    localparam int HT = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sck_i = 1'b0, mosi_i = 1'b0, sel_n_i = 1'b1;
    logic        sck_o, sck_oe, mosi_o, miso_o, sel_n_o, miso_i;
    int          checks = 0, fails = 0;

    always #4 clk = ~clk;
    assign miso_i = mosi_o;

    spi_char_engine #(.CHAR_W(8), .HALF_TICKS(HT)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_i(sck_i), .sck_o(sck_o),
        .sck_oe(sck_oe), .mosi_o(mosi_o), .mosi_i(mosi_i), .miso_o(miso_o),
        .miso_i(miso_i), .sel_n_o(sel_n_o), .sel_n_i(sel_n_i)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a; #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] mk(input logic [3:0] role, input logic [1:0] src,
                                       input bit cpha, input bit cpol, input bit clko, input bit wg);
        return {11'd0, wg, 1'b0, clko, 1'b0, cpol, 7'd0, cpha, 2'b11, src, role};
    endfunction

    // waits for a master character and records edges and sampled mosi bits
    task automatic observe(input bit cpha, output bit seen, output int nedge,
                           output logic [7:0] cap, output int dur);
        int t = 0;
        logic prev;
        nedge = 0; cap = '0; dur = 0;
        while (sel_n_o && t < 4000) begin @(negedge clk); t++; end
        seen = !sel_n_o;
        prev = sck_o;
        while (!sel_n_o && dur < 4000) begin
            @(negedge clk); dur++;
            if (sck_o != prev) begin
                if (((nedge % 2) == 0) ^ cpha) cap = {cap[6:0], mosi_o};
                nedge++;
                prev = sck_o;
            end
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        peek(ADR_MODE, d);  chk(d == 0, "R1 config", d, 0);
        peek(ADR_STAT, d);  chk(d == 1, "R1 status", d, 1);
        chk(sel_n_o == 1'b1, "R1 sel_n_o", sel_n_o, 1);
        chk(sck_oe == 1'b0, "R1 sck_oe", sck_oe, 0);
    endtask

    task automatic t_lock();
        logic [31:0] d;
        wr(ADR_WPROT, 1);
        wr(ADR_MODE, mk(ROLE_MASTER, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0));
        peek(ADR_MODE, d); chk(d == 0, "R8 locked write ignored", d, 0);
        wr(ADR_WPROT, 0);
        wr(ADR_MODE, mk(4'h0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0));
        peek(ADR_MODE, d);
        chk(d == mk(4'h0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0), "R8 unlocked write", d,
            mk(4'h0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0));
    endtask

    task automatic t_off();
        logic [31:0] d;
        bit seen; int n, dur; logic [7:0] cap;
        bit went_low = 1'b0;
        wr(ADR_MODE, mk(4'hD, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0));
        wr(ADR_TXH, 32'h11);
        for (int i = 0; i < 80; i++) begin @(negedge clk); if (!sel_n_o) went_low = 1'b1; end
        chk(!went_low, "R2 no start when role off", went_low, 0);
        peek(ADR_STAT, d); chk(d[0] == 1'b0, "R2 char stays pending", d[0], 0);
        wr(ADR_MODE, mk(ROLE_MASTER, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0));
        observe(1'b0, seen, n, cap, dur);
        chk(seen && cap == 8'h11, "R2 drains once enabled", cap, 8'h11);
        rd(ADR_RXH, d);
    endtask

    task automatic t_master(input bit cpol, input bit cpha, input logic [7:0] b, input bit tx_flag);
        logic [31:0] d;
        bit seen; int n, dur; logic [7:0] cap;
        wr(ADR_MODE, mk(ROLE_MASTER, 2'd0, cpha, cpol, 1'b1, 1'b0));
        repeat (3) @(negedge clk);
        chk(sck_o == cpol, "R4 idle level", sck_o, cpol);
        wr(ADR_TXH, {24'd0, b});
        if (tx_flag) begin
            peek(ADR_STAT, d); chk(d[0] == 1'b0, "R9 TXRDY cleared by write", d[0], 0);
            @(negedge clk); peek(ADR_STAT, d);
            chk(d[0] == 1'b1, "R9 TXRDY set after load", d[0], 1);
        end
        observe(cpha, seen, n, cap, dur);
        chk(seen && n == 16, "R4 edge count", n, 16);
        chk(cap == b, "R3 msb-first on mosi_o", cap, b);
        peek(ADR_STAT, d); chk(d[1] == 1'b1, "R3 RXRDY set", d[1], 1);
        rd(ADR_RXH, d); chk(d[7:0] == b, "R3 received byte", d[7:0], b);
        peek(ADR_STAT, d); chk(d[1] == 1'b0, "R3 RXRDY cleared by read", d[1], 0);
    endtask

    task automatic t_clko();
        wr(ADR_MODE, mk(ROLE_MASTER, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0));
        chk(sck_oe == 1'b1, "R6 internal source drives", sck_oe, 1);
        wr(ADR_MODE, mk(ROLE_MASTER, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0));
        chk(sck_oe == 1'b0, "R6 external source not driven", sck_oe, 0);
        wr(ADR_MODE, mk(ROLE_MASTER, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0));
        chk(sck_oe == 1'b0, "R6 clock-out off", sck_oe, 0);
        wr(ADR_MODE, mk(ROLE_SLAVE, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0));
        chk(sck_oe == 1'b0, "R6 slave never drives", sck_oe, 0);
    endtask

    task automatic t_div();
        logic [31:0] d;
        bit seen; int n, d0, d1; logic [7:0] cap;
        wr(ADR_MODE, mk(ROLE_MASTER, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0));
        wr(ADR_TXH, 32'h5A); observe(1'b0, seen, n, cap, d0); rd(ADR_RXH, d);
        wr(ADR_MODE, mk(ROLE_MASTER, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0));
        wr(ADR_TXH, 32'h5A); observe(1'b0, seen, n, cap, d1); rd(ADR_RXH, d);
        chk(d0 >= 16 * HT, "R5 base length", d0, 16 * HT);
        chk(d1 >= 7 * d0, "R5 divided length", d1, 7 * d0);
        chk(d[7:0] == 8'h5A, "R5 divided data", d[7:0], 8'h5A);
    endtask

    task automatic t_wait_read();
        logic [31:0] d;
        bit seen; int n, dur; logic [7:0] cap;
        bit went_low = 1'b0;
        wr(ADR_MODE, mk(ROLE_MASTER, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1));
        wr(ADR_TXH, 32'h55); observe(1'b0, seen, n, cap, dur);
        wr(ADR_TXH, 32'h66);
        for (int i = 0; i < 100; i++) begin @(negedge clk); if (!sel_n_o) went_low = 1'b1; end
        chk(!went_low, "R7 held while RXRDY set", went_low, 0);
        peek(ADR_STAT, d); chk(d[0] == 1'b0, "R7 still pending", d[0], 0);
        rd(ADR_RXH, d); chk(d[7:0] == 8'h55, "R7 first byte", d[7:0], 8'h55);
        observe(1'b0, seen, n, cap, dur);
        chk(seen && cap == 8'h66, "R7 starts after read", cap, 8'h66);
        rd(ADR_RXH, d);
    endtask

    task automatic t_overrun();
        logic [31:0] d;
        bit seen; int n, dur; logic [7:0] cap;
        wr(ADR_MODE, mk(ROLE_MASTER, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0));
        wr(ADR_TXH, 32'h12); observe(1'b1, seen, n, cap, dur);
        wr(ADR_TXH, 32'h34); observe(1'b1, seen, n, cap, dur);
        peek(ADR_STAT, d); chk(d[2:0] == 3'b111, "R10 overrun flagged", d[2:0], 7);
        rd(ADR_RXH, d); chk(d[7:0] == 8'h12, "R10 older byte kept", d[7:0], 8'h12);
        wr(ADR_STAT, 32'h4);
        peek(ADR_STAT, d); chk(d[2:0] == 3'b001, "R10 overrun cleared", d[2:0], 1);
    endtask

    task automatic t_slave(input bit cpol, input bit cpha, input logic [7:0] tx, input logic [7:0] rx);
        logic [31:0] d;
        logic [7:0] got = '0;
        localparam int H = 12;
        wr(ADR_MODE, mk(ROLE_SLAVE, 2'd3, cpha, cpol, 1'b0, 1'b0));
        wr(ADR_TXH, {24'd0, tx});
        sck_i = cpol; sel_n_i = 1'b0;
        repeat (10) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            if (!cpha) begin
                mosi_i = rx[7-i];
                repeat (H) @(negedge clk);
                got = {got[6:0], miso_o}; sck_i = ~cpol;
                repeat (H) @(negedge clk);
                sck_i = cpol;
            end else begin
                mosi_i = rx[7-i]; sck_i = ~cpol;
                repeat (H) @(negedge clk);
                got = {got[6:0], miso_o}; sck_i = cpol;
                repeat (H) @(negedge clk);
            end
        end
        repeat (10) @(negedge clk);
        sel_n_i = 1'b1;
        repeat (10) @(negedge clk);
        chk(got == tx, "R11 slave sends on miso_o", got, tx);
        rd(ADR_RXH, d); chk(d[7:0] == rx, "R11 slave receives", d[7:0], rx);
    endtask

    task automatic t_slave_ignored();
        logic [31:0] d;
        wr(ADR_MODE, mk(ROLE_SLAVE, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0));
        sel_n_i = 1'b1;
        for (int i = 0; i < 16; i++) begin
            mosi_i = i[0]; sck_i = ~sck_i;
            repeat (10) @(negedge clk);
        end
        repeat (10) @(negedge clk);
        peek(ADR_STAT, d); chk(d[1] == 1'b0, "R11 deselected edges ignored", d[1], 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_lock();
        t_off();
        t_master(1'b0, 1'b0, 8'hA5, 1'b1);
        t_master(1'b0, 1'b1, 8'h3C, 1'b0);
        t_master(1'b1, 1'b0, 8'h81, 1'b0);
        t_master(1'b1, 1'b1, 8'h6E, 1'b0);
        t_clko();
        t_div();
        t_wait_read();
        t_overrun();
        t_slave(1'b1, 1'b0, 8'h3C, 8'hA5);
        t_slave(1'b0, 1'b1, 8'hC6, 8'h19);
        t_slave_ignored();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all-requirements actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule